// File: doc/BRIEF.md
# USB Device Suspend and Resume Controller

This block handles power management for a USB peripheral. Software sets it up through a single one-byte control register, reached over a plain write/read strobe bus. A free-running millisecond tick input supplies the time base. The block watches a bus-activity strobe and raises a suspend interrupt once the bus has been quiet long enough. It enters suspend only after software runs a set-then-clear handshake. After entering suspend it can stop the internal clock-enable. On request it drives timed upstream resume signalling. It also drives a suspend status pin in one of two styles, and it brings out the pull-up enable and a soft-reset pulse.

The main state machine has four states:
- `PM_AWAKE`: normal operation, with the idle monitor running.
- `PM_SUSPEND`: suspended, with the clock still enabled.
- `PM_CLK_OFF`: suspended, with the clock-enable low.
- `PM_SETTLE`: clock restarted but not yet declared stable.

Its transitions are:
- **enter** (`PM_AWAKE`→`PM_SUSPEND`): on the clearing write of the go-suspend bit.
- **stop** (`PM_SUSPEND`→`PM_CLK_OFF`): once the clock-stop delay has elapsed and the keep-clock bit is 0.
- **quick wake** (`PM_SUSPEND`→`PM_AWAKE`): on a wake event.
- **restart** (`PM_CLK_OFF`→`PM_SETTLE`): on a wake event.
- **ready** (`PM_SETTLE`→`PM_AWAKE`): after the settle delay.

A wake event is either host resume or an enabled register read.

A separate resume generator has three states:
- `RS_IDLE`: nothing pending.
- `RS_WAIT`: lead-in delay running.
- `RS_DRIVE`: resume signalling driven.

Its transitions are **arm** (`RS_IDLE`→`RS_WAIT`), **start** (`RS_WAIT`→`RS_DRIVE`) and **done** (`RS_DRIVE`→`RS_IDLE`).

Control register bits, by position:

| Bit | Meaning |
| --- | --- |
| 7 | keep clock on in suspend |
| 6 | send-resume |
| 5 | go-suspend |
| 4 | soft-reset |
| 3 | interrupt enable |
| 2 | wake on register read |
| 1 | pin style (0 = level, 1 = wake pulse) |
| 0 | pull-up connect |

Top module: `usb_pm_ctrl`

## Requirements
- R1: After reset `reg_rdata` is 0x00, `clk_en` and `clk_stable` are 1, and `susp_irq`, `susp_pin`, `resume_drv`, `pullup_en` and `soft_rst` are 0.
- R2: While `clk_stable` is 1, a write stores `reg_wdata`, and `reg_rdata` returns it on the next cycle. `pullup_en` always equals bit 0 of the register.
- R3: While awake, IDLE_MS ticks with no `bus_act` produce a single one-cycle `susp_irq` pulse. This happens whatever the value of bit 0.
- R4: Any `bus_act` pulse restarts the idle count, so activity at intervals shorter than IDLE_MS ticks never raises `susp_irq`.
- R5: With bit 3 at 0, `susp_irq` stays low.
- R6: Writing 1 to bit 5 does not suspend. The following write that clears it enters suspend. If bit 7 is 0, `clk_en` falls CLK_STOP_MS ticks later. If bit 7 is 1, `clk_en` stays 1 throughout suspend.
- R7: In level style (bit 1 = 0), `susp_pin` is 1 exactly while suspended (`PM_SUSPEND` or `PM_CLK_OFF`).
- R8: While `clk_stable` is 0, register writes are ignored.
- R9: A `host_resume` pulse while suspended wakes the device. `clk_en` is 1 from the next cycle.
- R10: `clk_stable` is 0 whenever `clk_en` is 0. After a wake from `PM_CLK_OFF`, `clk_stable` returns SETTLE_MS ticks later.
- R11: In pulse style (bit 1 = 1), `susp_pin` stays low while suspended. On wake-up it gives one high pulse of WAKE_PULSE_MS ticks.
- R12: A set-then-clear of bit 6 raises `resume_drv` RSM_DELAY_MS ticks after the clearing write, and holds it for RSM_LEN_MS ticks.
- R13: A set-then-clear of bit 4 gives a one-cycle `soft_rst` pulse. After the pulse, the register and all internal state return to their reset values.
- R14: A `reg_rd` while suspended wakes the device only if bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bus_act | input | 1 | Bus-activity strobe |
| host_resume | input | 1 | Host resume detected on the bus |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register contents |
| susp_irq | output | 1 | Suspend interrupt pulse |
| clk_en | output | 1 | Internal clock enable |
| clk_stable | output | 1 | Clock settled, writes accepted |
| resume_drv | output | 1 | Drive upstream resume signalling |
| susp_pin | output | 1 | Suspend status pin |
| pullup_en | output | 1 | Pull-up connect |
| soft_rst | output | 1 | Software reset pulse |

## Verification
A state machine stuck in or skipping `PM_SUSPEND` shows at `susp_pin` one cycle after the clearing write in level style. A wrong clock-stop or settle count shows as `clk_en` or `clk_stable` moving one or more ticks off the expected edge. A resume generator in the wrong state moves the `resume_drv` rise or fall by whole ticks, so every delay is checked against tick counts with a one-tick margin. A trigger latch taken from the wrong write shows up as an action that follows the setting write instead of the clearing one, detectable within the first delay window.

// File: rtl/usb_pm_pkg.sv
package usb_pm_pkg;

    localparam int MODE_W = 8;

    // control register bit positions (software decodes these)
    localparam int B_CLK_AON  = 7;
    localparam int B_SEND_RSM = 6;
    localparam int B_GO_SUSP  = 5;
    localparam int B_SOFT_RST = 4;
    localparam int B_IRQ_EN   = 3;
    localparam int B_WAKE_RD  = 2;
    localparam int B_PIN_MODE = 1;
    localparam int B_CONNECT  = 0;

    typedef enum logic [1:0] {
        PM_AWAKE,
        PM_SUSPEND,
        PM_CLK_OFF,
        PM_SETTLE
    } pm_state_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_WAIT,
        RS_DRIVE
    } rsm_state_e;

endpackage

// File: rtl/usb_pm_modereg.sv
module usb_pm_modereg
    import usb_pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              reg_wr,
    input  logic [MODE_W-1:0] reg_wdata,
    output logic [MODE_W-1:0] mode,
    output logic              susp_trig,
    output logic              rsm_trig,
    output logic              soft_rst
);

    logic wr_fire;

    assign wr_fire = reg_wr && wr_ok && !soft_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode      <= '0;
            susp_trig <= 1'b0;
            rsm_trig  <= 1'b0;
            soft_rst  <= 1'b0;
        end else begin
            // actions fire on the write that clears a previously set bit
            susp_trig <= wr_fire && mode[B_GO_SUSP]  && !reg_wdata[B_GO_SUSP];
            rsm_trig  <= wr_fire && mode[B_SEND_RSM] && !reg_wdata[B_SEND_RSM];
            soft_rst  <= wr_fire && mode[B_SOFT_RST] && !reg_wdata[B_SOFT_RST];
            if (soft_rst) begin
                mode <= '0;
            end else if (wr_fire) begin
                mode <= reg_wdata;
            end
        end
    end

endmodule

// File: rtl/usb_pm_idle.sv
module usb_pm_idle #(
    parameter int IDLE_MS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic bus_act,
    input  logic ms_tick,
    output logic fire
);

    localparam int CW = $clog2(IDLE_MS + 1);

    logic [CW-1:0] cnt;
    logic          fired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            fired <= 1'b0;
            fire  <= 1'b0;
        end else if (clr || !run || bus_act) begin
            cnt   <= '0;
            fired <= 1'b0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (ms_tick && !fired) begin
                if (cnt == CW'(IDLE_MS - 1)) begin
                    fired <= 1'b1;
                    fire  <= 1'b1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/usb_pm_resume.sv
module usb_pm_resume
    import usb_pm_pkg::*;
#(
    parameter int DLY_MS = 5,
    parameter int LEN_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic ms_tick,
    output logic drive
);

    localparam int MAXV = (DLY_MS > LEN_MS) ? DLY_MS : LEN_MS;
    localparam int CW   = $clog2(MAXV + 1);

    rsm_state_e    state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            RS_IDLE:  if (start) nxt = RS_WAIT;
            RS_WAIT:  if (ms_tick && cnt == CW'(DLY_MS - 1)) nxt = RS_DRIVE;
            RS_DRIVE: if (ms_tick && cnt == CW'(LEN_MS - 1)) nxt = RS_IDLE;
            default:  nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            cnt   <= '0;
        end else if (clr) begin
            state <= RS_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || state == RS_IDLE) begin
                cnt <= '0;
            end else if (ms_tick) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    always_comb begin
        drive = (state == RS_DRIVE);
    end

endmodule

// File: rtl/usb_pm_fsm.sv
module usb_pm_fsm
    import usb_pm_pkg::*;
#(
    parameter int STOP_MS   = 2,
    parameter int SETTLE_MS = 2,
    parameter int PULSE_MS  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic susp_trig,
    input  logic clk_aon,
    input  logic pin_mode,
    input  logic wake_rd_en,
    input  logic reg_rd,
    input  logic host_resume,
    input  logic ms_tick,
    output logic clk_en,
    output logic clk_stable,
    output logic susp_pin,
    output logic awake
);

    localparam int MAXV = (STOP_MS > SETTLE_MS) ? STOP_MS : SETTLE_MS;
    localparam int CW   = $clog2(MAXV + 1);
    localparam int PW   = $clog2(PULSE_MS + 1);

    pm_state_e     state, nxt;
    logic [CW-1:0] cnt;
    logic [PW-1:0] pcnt;
    logic          pulse_on;
    logic          wake;
    logic          suspended;
    logic          wake_evt;

    assign wake      = host_resume || (reg_rd && wake_rd_en);
    assign suspended = (state == PM_SUSPEND) || (state == PM_CLK_OFF);
    assign wake_evt  = suspended && wake;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            PM_AWAKE:   if (susp_trig) nxt = PM_SUSPEND;
            PM_SUSPEND: begin
                if (wake) begin
                    nxt = PM_AWAKE;
                end else if (!clk_aon && ms_tick && cnt == CW'(STOP_MS - 1)) begin
                    nxt = PM_CLK_OFF;
                end
            end
            PM_CLK_OFF: if (wake) nxt = PM_SETTLE;
            PM_SETTLE:  if (ms_tick && cnt == CW'(SETTLE_MS - 1)) nxt = PM_AWAKE;
            default:    nxt = PM_AWAKE;
        endcase
    end

    // state register and delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PM_AWAKE;
            cnt   <= '0;
        end else if (clr) begin
            state <= PM_AWAKE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || state == PM_AWAKE || state == PM_CLK_OFF ||
                (state == PM_SUSPEND && clk_aon)) begin
                cnt <= '0;
            end else if (ms_tick) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // output process: wake pulse timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_on <= 1'b0;
            pcnt     <= '0;
        end else if (clr) begin
            pulse_on <= 1'b0;
            pcnt     <= '0;
        end else if (wake_evt) begin
            pulse_on <= 1'b1;
            pcnt     <= '0;
        end else if (pulse_on && ms_tick) begin
            if (pcnt == PW'(PULSE_MS - 1)) begin
                pulse_on <= 1'b0;
            end else begin
                pcnt <= pcnt + PW'(1);
            end
        end
    end

    always_comb begin
        clk_en     = (state != PM_CLK_OFF);
        clk_stable = (state == PM_AWAKE) || (state == PM_SUSPEND);
        susp_pin   = pin_mode ? pulse_on : suspended;
        awake      = (state == PM_AWAKE);
    end

endmodule

// File: rtl/usb_pm_ctrl.sv
module usb_pm_ctrl
    import usb_pm_pkg::*;
#(
    parameter int IDLE_MS       = 3,
    parameter int CLK_STOP_MS   = 2,
    parameter int RSM_DELAY_MS  = 5,
    parameter int RSM_LEN_MS    = 10,
    parameter int WAKE_PULSE_MS = 1,
    parameter int SETTLE_MS     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              bus_act,
    input  logic              host_resume,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [MODE_W-1:0] reg_wdata,
    output logic [MODE_W-1:0] reg_rdata,
    output logic              susp_irq,
    output logic              clk_en,
    output logic              clk_stable,
    output logic              resume_drv,
    output logic              susp_pin,
    output logic              pullup_en,
    output logic              soft_rst
);

    logic [MODE_W-1:0] mode;
    logic              susp_trig;
    logic              rsm_trig;
    logic              idle_fire;
    logic              awake;
    logic              irq_q;

    usb_pm_modereg i_modereg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (clk_stable),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .mode      (mode),
        .susp_trig (susp_trig),
        .rsm_trig  (rsm_trig),
        .soft_rst  (soft_rst)
    );

    usb_pm_idle #(.IDLE_MS(IDLE_MS)) i_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .run     (awake),
        .bus_act (bus_act),
        .ms_tick (ms_tick),
        .fire    (idle_fire)
    );

    usb_pm_resume #(.DLY_MS(RSM_DELAY_MS), .LEN_MS(RSM_LEN_MS)) i_resume (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .start   (rsm_trig),
        .ms_tick (ms_tick),
        .drive   (resume_drv)
    );

    usb_pm_fsm #(
        .STOP_MS   (CLK_STOP_MS),
        .SETTLE_MS (SETTLE_MS),
        .PULSE_MS  (WAKE_PULSE_MS)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (soft_rst),
        .susp_trig   (susp_trig),
        .clk_aon     (mode[B_CLK_AON]),
        .pin_mode    (mode[B_PIN_MODE]),
        .wake_rd_en  (mode[B_WAKE_RD]),
        .reg_rd      (reg_rd),
        .host_resume (host_resume),
        .ms_tick     (ms_tick),
        .clk_en      (clk_en),
        .clk_stable  (clk_stable),
        .susp_pin    (susp_pin),
        .awake       (awake)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (soft_rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= idle_fire && mode[B_IRQ_EN];
        end
    end

    assign susp_irq  = irq_q;
    assign reg_rdata = mode;
    assign pullup_en = mode[B_CONNECT];

endmodule

// File: rtl/usb_pm_ctrl_chk.sv
module usb_pm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic       susp_irq,
    input logic       clk_en,
    input logic       clk_stable,
    input logic       susp_pin,
    input logic       pullup_en,
    input logic       soft_rst
);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        susp_irq |=> !susp_irq); // R3

    AST_STABLE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !clk_stable); // R10

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !clk_stable && !soft_rst) |=> $stable(reg_rdata)); // R8

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (reg_rdata == 8'h00 && !pullup_en && !soft_rst)); // R13

    AST_LEVEL_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[1] && !clk_en) |-> susp_pin); // R7

    AST_PULSE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && !clk_en) |-> !susp_pin); // R11

endmodule

bind usb_pm_ctrl usb_pm_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .susp_irq   (susp_irq),
    .clk_en     (clk_en),
    .clk_stable (clk_stable),
    .susp_pin   (susp_pin),
    .pullup_en  (pullup_en),
    .soft_rst   (soft_rst)
);

// File: tb/test_usb_pm_ctrl.sv
`timescale 1ns/1ps
module test_usb_pm_ctrl;

    localparam int TICK_CYC = 20;
    localparam int S_MEAS = 0, S_RDATA = 1, S_CLKEN = 2, S_STABLE = 3, S_PIN = 4,
                   S_RSM = 5, S_PULLUP = 6, S_IRQ = 7, S_SRST = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       bus_act = 1'b0;
    logic       host_resume = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       susp_irq, clk_en, clk_stable, resume_drv, susp_pin, pullup_en, soft_rst;

    int n_chk = 0;
    int n_err = 0;
    int tick_cnt = 0;
    int irq_cnt = 0;
    int srst_cnt = 0;
    bit done = 0;

    typedef struct {
        string req;
        string what;
        int    sig;
        int    got;
        int    exp;
        int    tol;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    usb_pm_ctrl i_usb_pm_ctrl (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bus_act(bus_act),
        .host_resume(host_resume), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .susp_irq(susp_irq),
        .clk_en(clk_en), .clk_stable(clk_stable), .resume_drv(resume_drv),
        .susp_pin(susp_pin), .pullup_en(pullup_en), .soft_rst(soft_rst)
    );

    function automatic int port_val(int sig);
        case (sig)
            S_RDATA:  return int'(reg_rdata);
            S_CLKEN:  return int'(clk_en);
            S_STABLE: return int'(clk_stable);
            S_PIN:    return int'(susp_pin);
            S_RSM:    return int'(resume_drv);
            S_PULLUP: return int'(pullup_en);
            S_IRQ:    return int'(susp_irq);
            S_SRST:   return int'(soft_rst);
            default:  return 0;
        endcase
    endfunction

    // tick generator and event counters
    initial begin
        forever begin
            repeat (TICK_CYC - 1) @(negedge clk);
            ms_tick = 1'b1;
            tick_cnt++;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (susp_irq) irq_cnt++;
        if (soft_rst) srst_cnt++;
    end

    // monitor: pops expectations, samples the ports, compares
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            begin
                item_t it;
                int    act;
                int    d;
                it  = exp_q.pop_front();
                act = (it.sig == S_MEAS) ? it.got : port_val(it.sig);
                d   = act - it.exp;
                if (d < 0) d = -d;
                n_chk++;
                if (d > it.tol) begin
                    n_err++;
                    $display("FAIL %s %s: actual %0d expected %0d", it.req, it.what, act, it.exp);
                end
            end
        end
    end

    task automatic expect_port(string req, string what, int sig, int exp);
        item_t it;
        it.req = req; it.what = what; it.sig = sig; it.got = 0; it.exp = exp; it.tol = 0;
        exp_q.push_back(it);
    endtask

    task automatic expect_val(string req, string what, int got, int exp, int tol);
        item_t it;
        it.req = req; it.what = what; it.sig = S_MEAS; it.got = got; it.exp = exp; it.tol = tol;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic strobe_rd();
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic strobe_act();
        @(negedge clk); bus_act = 1'b1;
        @(negedge clk); bus_act = 1'b0;
    endtask

    task automatic strobe_hres();
        @(negedge clk); host_resume = 1'b1;
        @(negedge clk); host_resume = 1'b0;
    endtask

    task automatic wait_ticks(int n);
        int t0;
        t0 = tick_cnt;
        while (tick_cnt < t0 + n) @(negedge clk);
    endtask

    task automatic measure(int sig, int val, output int dt);
        int t0;
        int guard;
        t0 = tick_cnt;
        guard = 0;
        while (port_val(sig) != val && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        dt = tick_cnt - t0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int dt;
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_port("R1", "rdata", S_RDATA, 0);
        expect_port("R1", "clk_en", S_CLKEN, 1);
        expect_port("R1", "clk_stable", S_STABLE, 1);
        expect_port("R1", "susp_pin", S_PIN, 0);
        expect_port("R1", "resume_drv", S_RSM, 0);
        expect_port("R1", "pullup_en", S_PULLUP, 0);
        expect_port("R1", "susp_irq", S_IRQ, 0);
        expect_port("R1", "soft_rst", S_SRST, 0);

        // R2 readback and pull-up
        wr(8'h09);
        expect_port("R2", "rdata", S_RDATA, 8'h09);
        expect_port("R2", "pullup_en on", S_PULLUP, 1);

        // R3 idle interrupt, connected
        strobe_act();
        measure(S_IRQ, 1, dt);
        expect_val("R3", "idle delay connected", dt, 3, 1);

        // R3 idle interrupt, disconnected
        wr(8'h08);
        expect_port("R2", "pullup_en off", S_PULLUP, 0);
        strobe_act();
        measure(S_IRQ, 1, dt);
        expect_val("R3", "idle delay disconnected", dt, 3, 1);
        @(negedge clk);
        expect_port("R3", "irq one cycle", S_IRQ, 0);

        // R4 activity restarts the count
        snap = irq_cnt;
        for (int i = 0; i < 6; i++) begin
            strobe_act();
            wait_ticks(2);
        end
        expect_val("R4", "irq during activity", irq_cnt - snap, 0, 0);

        // R5 interrupt enable gate
        wr(8'h00);
        snap = irq_cnt;
        strobe_act();
        wait_ticks(6);
        expect_val("R5", "irq while disabled", irq_cnt - snap, 0, 0);

        // R6 setting write alone does not suspend; clearing write does
        wr(8'h28);
        wait_ticks(3);
        expect_port("R6", "clk_en after set only", S_CLKEN, 1);
        expect_port("R7", "pin after set only", S_PIN, 0);
        wr(8'h08);
        @(negedge clk); @(negedge clk);
        expect_port("R7", "level pin suspended", S_PIN, 1);
        measure(S_CLKEN, 0, dt);
        expect_val("R6", "clock stop delay", dt, 2, 1);
        expect_port("R10", "stable low with clock off", S_STABLE, 0);

        // R8 write ignored while unstable
        wr(8'hFF);
        expect_port("R8", "rdata unchanged", S_RDATA, 8'h08);

        // R14 read does not wake when disabled
        strobe_rd();
        @(negedge clk);
        expect_port("R14", "clk_en after read, wake off", S_CLKEN, 0);

        // R9 host resume wake, R10 settle
        strobe_hres();
        expect_port("R9", "clk_en after host resume", S_CLKEN, 1);
        expect_port("R7", "level pin awake", S_PIN, 0);
        measure(S_STABLE, 1, dt);
        expect_val("R10", "settle delay", dt, 2, 1);

        // R11 pulse style with R14 read wake
        wr(8'h0E);
        wr(8'h2E);
        wr(8'h0E);
        measure(S_CLKEN, 0, dt);
        expect_val("R6", "clock stop delay pulse style", dt, 2, 1);
        expect_port("R11", "pin low while suspended", S_PIN, 0);
        strobe_rd();
        expect_port("R14", "clk_en after read, wake on", S_CLKEN, 1);
        expect_port("R11", "wake pulse high", S_PIN, 1);
        measure(S_PIN, 0, dt);
        expect_val("R11", "wake pulse width", dt, 1, 1);
        measure(S_STABLE, 1, dt);

        // R6 keep-clock suspend
        wr(8'h88);
        wr(8'hA8);
        wr(8'h88);
        wait_ticks(5);
        expect_port("R6", "clk_en kept", S_CLKEN, 1);
        expect_port("R7", "level pin kept clock", S_PIN, 1);
        strobe_hres();
        expect_port("R9", "pin after host resume", S_PIN, 0);

        // R12 resume signalling
        wr(8'h48);
        wr(8'h08);
        expect_port("R12", "resume not yet", S_RSM, 0);
        measure(S_RSM, 1, dt);
        expect_val("R12", "resume lead-in", dt, 5, 1);
        measure(S_RSM, 0, dt);
        expect_val("R12", "resume length", dt, 10, 1);

        // R13 soft reset
        snap = srst_cnt;
        wr(8'h19);
        expect_val("R13", "no reset on set", srst_cnt - snap, 0, 0);
        wr(8'h09);
        @(negedge clk); @(negedge clk);
        expect_val("R13", "one reset pulse", srst_cnt - snap, 1, 0);
        expect_port("R13", "rdata cleared", S_RDATA, 0);
        expect_port("R13", "pullup cleared", S_PULLUP, 0);

        wait (exp_q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule